// File: doc/BRIEF.md
# Interval Timer Pair with Shared Interrupt

This block holds two 16-bit down-counting interval timers behind a byte-wide register port indexed by a 4-bit register number. Both counters decrement by one on each cycle in which the prescaler tick input is high. The first timer also has a reload register and two modes, chosen by an auxiliary control byte. In continuous mode every expiry reloads the counter and raises a flag. In one-shot mode the flag is raised once after the counter is written. The second timer is a bare counter that wraps.

The first timer's flag sits in a flag byte next to an enable byte. The interrupt output is a registered OR over the enabled flags. A counter byte write keeps the live value of the other byte. A read of either byte of the first counter acknowledges its flag. The enable byte uses its top bit to choose between setting and clearing the bits written. Read data is registered and appears in the cycle after the read strobe.

Top module: `latched_interval_timer`

## Requirements
- R1: After reset both counters and the reload register read 0xFFFF, so the reload period is 65536 ticks. The auxiliary control byte, the flag byte, the enable byte, irq and rd_data are all 0.
- R2: A counter decrements by one on each cycle with tick_en high and holds on other cycles. Timer 1 uses index 4 for its low byte and 5 for its high byte; timer 2 uses 8 and 9. Leaving continuous mode stops the flags, but the counter keeps running and wraps from 0 to 0xFFFF.
- R3: A write to a low counter byte loads that byte together with the live high byte. A write to a high counter byte loads that byte together with the live low byte. A counter write in the same cycle as a tick takes precedence over the decrement.
- R4: The auxiliary control byte is at index 11. When its bits 7:6 equal 01, a tick at count 0 on timer 1 reloads the counter from the reload register and sets flag bit 6. The period is therefore the reload value plus one ticks. The reload register's low byte is at index 6 and its high byte at index 7.
- R5: With bits 7:6 of the auxiliary control byte not equal to 01, timer 1 wraps to 0xFFFF at expiry. Flag bit 6 is set only at the first expiry after a write to index 4 or 5.
- R6: A read of index 4 or 5 clears flag bit 6. If an expiry sets the flag in the same cycle, the set wins.
- R7: A write to the flag byte (index 13) clears each flag bit written as 1 and leaves the others unchanged. A read of index 13 returns the flags in bits 6:0 and 0 in bit 7.
- R8: A write to the enable byte (index 14) with bit 7 = 1 sets the enable bits given as 1 in bits 6:0. With bit 7 = 0 it clears them. A read of index 14 returns the enables with bit 7 = 0.
- R9: irq is 1 exactly one cycle after a cycle in which some flag bit and its enable bit are both 1.
- R10: rd_data changes only in the cycle after rd_en and shows the register contents of the rd_en cycle. Indices 0 to 3, 10, 12 and 15 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 4 | Register index |
| wr_data | input | 8 | Write data |
| tick_en | input | 1 | Prescaler tick, one count per high cycle |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is the one-shot rule. After a one-shot expiry the counter wraps to 0xFFFF, and it can reach zero again only after a full 65536-tick lap with no counter write, because any counter write would re-arm the flag. The bench runs that entire lap with the flag enabled and watches irq on every cycle. A second hard case is a counter read in the same cycle as a continuous-mode expiry. To hit that coincidence, the stimulus reads the counter on every cycle through several short reload periods.

// File: rtl/lit_pkg.sv
package lit_pkg;
   localparam logic [3:0] IDX_T1_LO  = 4'd4;
   localparam logic [3:0] IDX_T1_HI  = 4'd5;
   localparam logic [3:0] IDX_RL_LO  = 4'd6;
   localparam logic [3:0] IDX_RL_HI  = 4'd7;
   localparam logic [3:0] IDX_T2_LO  = 4'd8;
   localparam logic [3:0] IDX_T2_HI  = 4'd9;
   localparam logic [3:0] IDX_AUX    = 4'd11;
   localparam logic [3:0] IDX_FLAG   = 4'd13;
   localparam logic [3:0] IDX_ENA    = 4'd14;
   localparam int         T1_FLAG_BIT = 6;
   localparam logic [1:0] MODE_CONT  = 2'b01;
endpackage

// File: rtl/lit_counter.sv
module lit_counter #(
   parameter int CNT_W      = 16,
   parameter bit HAS_RELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wr_byte,
   input  logic             reload_en,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   localparam int HI_W = CNT_W - 8;
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   logic [CNT_W-1:0] wrap_val;

   generate
      if (HAS_RELOAD) begin : g_reload
         assign wrap_val = reload_en ? reload_val : ALL_ONES;
      end else begin : g_plain
         logic unused_rl;
         assign unused_rl = reload_en ^ (^reload_val);
         assign wrap_val  = ALL_ONES;
      end
   endgenerate

   assign expire = tick && !wr_lo && !wr_hi && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= ALL_ONES;
      end else if (wr_lo) begin
         cnt <= {cnt[CNT_W-1:8], wr_byte};
      end else if (wr_hi) begin
         cnt <= {wr_byte[HI_W-1:0], cnt[7:0]};
      end else if (tick) begin
         cnt <= (cnt == '0) ? wrap_val : cnt - 1'b1;
      end
   end
endmodule

// File: rtl/lit_irq.sv
module lit_irq #(
   parameter int NFLAG = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_vec,
   input  logic [NFLAG-1:0] clr_vec,
   input  logic             ena_wr,
   input  logic [7:0]       ena_data,
   output logic [NFLAG-1:0] flags,
   output logic [NFLAG-1:0] enables,
   output logic             irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags   <= '0;
         enables <= '0;
         irq     <= 1'b0;
      end else begin
         flags <= (flags & ~clr_vec) | set_vec;
         irq   <= |(flags & enables);
         if (ena_wr) begin
            if (ena_data[7]) enables <= enables | ena_data[NFLAG-1:0];
            else             enables <= enables & ~ena_data[NFLAG-1:0];
         end
      end
   end
endmodule

// File: rtl/latched_interval_timer.sv
module latched_interval_timer #(
   parameter int CNT_W  = 16,
   parameter bit HAS_T2 = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [3:0] reg_idx,
   input  logic [7:0] wr_data,
   input  logic       tick_en,
   output logic [7:0] rd_data,
   output logic       irq
);
   import lit_pkg::*;
   localparam int NFLAG = 7;
   localparam int HI_W  = CNT_W - 8;

   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
         $error("latched_interval_timer: CNT_W must lie in 9..16");
      end
   endgenerate

   logic [CNT_W-1:0] t1_cnt, t1_latch, t2_cnt;
   logic [7:0]       aux;
   logic             t1_cont, t1_armed, t1_exp, t1_set, t2_exp;
   logic [NFLAG-1:0] flags, enables, set_vec, clr_vec;
   logic             wr_t1lo, wr_t1hi, rd_t1;

   assign wr_t1lo = wr_en && reg_idx == IDX_T1_LO;
   assign wr_t1hi = wr_en && reg_idx == IDX_T1_HI;
   assign rd_t1   = rd_en && (reg_idx == IDX_T1_LO || reg_idx == IDX_T1_HI);
   assign t1_cont = aux[7:6] == MODE_CONT;
   assign t1_set  = t1_exp && (t1_cont || t1_armed);

   lit_counter #(.CNT_W(CNT_W), .HAS_RELOAD(1'b1)) u_t1 (
      .clk, .rst_n, .tick(tick_en), .wr_lo(wr_t1lo), .wr_hi(wr_t1hi),
      .wr_byte(wr_data), .reload_en(t1_cont), .reload_val(t1_latch),
      .cnt(t1_cnt), .expire(t1_exp));

   generate
      if (HAS_T2) begin : g_t2
         lit_counter #(.CNT_W(CNT_W), .HAS_RELOAD(1'b0)) u_t2 (
            .clk, .rst_n, .tick(tick_en),
            .wr_lo(wr_en && reg_idx == IDX_T2_LO),
            .wr_hi(wr_en && reg_idx == IDX_T2_HI),
            .wr_byte(wr_data), .reload_en(1'b0), .reload_val('0),
            .cnt(t2_cnt), .expire(t2_exp));
      end else begin : g_no_t2
         assign t2_cnt = '0;
         assign t2_exp = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t1_latch <= '1;
         aux      <= '0;
         t1_armed <= 1'b0;
      end else begin
         if (wr_en && reg_idx == IDX_RL_LO) t1_latch[7:0] <= wr_data;
         if (wr_en && reg_idx == IDX_RL_HI) t1_latch[CNT_W-1:8] <= wr_data[HI_W-1:0];
         if (wr_en && reg_idx == IDX_AUX)   aux <= wr_data;
         if (wr_t1lo || wr_t1hi)            t1_armed <= 1'b1;
         else if (t1_exp)                   t1_armed <= 1'b0;
      end
   end

   always_comb begin
      set_vec = '0;
      set_vec[T1_FLAG_BIT] = t1_set;
      clr_vec = (wr_en && reg_idx == IDX_FLAG) ? wr_data[NFLAG-1:0] : '0;
      if (rd_t1) clr_vec[T1_FLAG_BIT] = 1'b1;
   end

   lit_irq #(.NFLAG(NFLAG)) u_irq (
      .clk, .rst_n, .set_vec, .clr_vec,
      .ena_wr(wr_en && reg_idx == IDX_ENA), .ena_data(wr_data),
      .flags, .enables, .irq);

   logic [7:0] rd_next;
   always_comb begin
      unique case (reg_idx)
         IDX_T1_LO: rd_next = t1_cnt[7:0];
         IDX_T1_HI: rd_next = 8'(t1_cnt >> 8);
         IDX_RL_LO: rd_next = t1_latch[7:0];
         IDX_RL_HI: rd_next = 8'(t1_latch >> 8);
         IDX_T2_LO: rd_next = t2_cnt[7:0];
         IDX_T2_HI: rd_next = 8'(t2_cnt >> 8);
         IDX_AUX:   rd_next = aux;
         IDX_FLAG:  rd_next = {1'b0, flags};
         IDX_ENA:   rd_next = {1'b0, enables};
         default:   rd_next = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end

   logic unused_t2;
   assign unused_t2 = t2_exp;
endmodule

// File: rtl/latched_interval_timer_chk.sv
module latched_interval_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [3:0]       reg_idx,
   input logic [7:0]       wr_data,
   input logic             tick_en,
   input logic             irq,
   input logic [CNT_W-1:0] t1_cnt,
   input logic [CNT_W-1:0] t1_latch,
   input logic [6:0]       flags,
   input logic [6:0]       enables,
   input logic             t1_set,
   input logic             t1_cont
);
   logic t1_wr;
   assign t1_wr = wr_en && (reg_idx == 4'd4 || reg_idx == 4'd5);

   a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !t1_wr) |=> $stable(t1_cnt));

   a_r4_cont_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !t1_wr && t1_cnt == '0 && t1_cont) |=> (t1_cnt == $past(t1_latch) && flags[6]));

   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (reg_idx == 4'd4 || reg_idx == 4'd5) && !t1_set) |=> !flags[6]);

   a_r8_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_idx == 4'd14 && wr_data[7]) |=> ((enables & $past(wr_data[6:0])) == $past(wr_data[6:0])));

   a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags & enables)) |=> irq);

   a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(flags & enables)) |=> !irq);
endmodule

bind latched_interval_timer latched_interval_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_latched_interval_timer.sv
module tb_latched_interval_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, tick_en = 1'b0;
   logic [3:0] reg_idx = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq;

   latched_interval_timer dut (.clk, .rst_n, .wr_en, .rd_en, .reg_idx,
                               .wr_data, .tick_en, .rd_data, .irq);

   always #4 clk = ~clk;

   int    n_cmp = 0, n_bad = 0;
   bit    cmp_on = 1'b0, done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_c1, m_c2, m_latch, m_aux, m_flag, m_en, m_armed, m_irq, m_rd;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_c1 = 'hFFFF; m_c2 = 'hFFFF; m_latch = 'hFFFF; m_aux = 0;
         m_flag = 0; m_en = 0; m_armed = 0; m_irq = 0; m_rd = 0;
      end else begin
         int idx, d, clr, exp1;
         bit cont;
         idx = reg_idx; d = wr_data;
         cont = ((m_aux >> 6) & 3) == 1;
         m_irq = ((m_flag & m_en) != 0) ? 1 : 0;
         if (rd_en) begin
            case (idx)
               4: m_rd = m_c1 & 'hFF;   5: m_rd = m_c1 >> 8;
               6: m_rd = m_latch & 'hFF; 7: m_rd = m_latch >> 8;
               8: m_rd = m_c2 & 'hFF;   9: m_rd = m_c2 >> 8;
               11: m_rd = m_aux; 13: m_rd = m_flag; 14: m_rd = m_en;
               default: m_rd = 0;
            endcase
         end
         exp1 = 0;
         if (wr_en && idx == 4)      begin m_c1 = (m_c1 & 'hFF00) | d; m_armed = 1; end
         else if (wr_en && idx == 5) begin m_c1 = (d << 8) | (m_c1 & 'hFF); m_armed = 1; end
         else if (tick_en) begin
            if (m_c1 == 0) begin exp1 = 1; m_c1 = cont ? m_latch : 'hFFFF; end
            else m_c1 = m_c1 - 1;
         end
         if (wr_en && idx == 8)      m_c2 = (m_c2 & 'hFF00) | d;
         else if (wr_en && idx == 9) m_c2 = (d << 8) | (m_c2 & 'hFF);
         else if (tick_en)           m_c2 = (m_c2 == 0) ? 'hFFFF : m_c2 - 1;
         if (wr_en && idx == 6)  m_latch = (m_latch & 'hFF00) | d;
         if (wr_en && idx == 7)  m_latch = (d << 8) | (m_latch & 'hFF);
         if (wr_en && idx == 11) m_aux = d;
         clr = (wr_en && idx == 13) ? (d & 'h7F) : 0;
         if (rd_en && (idx == 4 || idx == 5)) clr = clr | 'h40;
         m_flag = m_flag & ~clr & 'h7F;
         if (exp1 && (cont || m_armed)) m_flag = m_flag | 'h40;
         if (exp1) m_armed = 0;
         if (wr_en && idx == 14) begin
            if (d & 'h80) m_en = m_en | (d & 'h7F);
            else          m_en = m_en & ~d & 'h7F;
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         n_cmp++;
         if (rd_data !== 8'(m_rd) || irq !== m_irq[0]) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h irq=%b expected rd_data=%02h irq=%0d",
                     cur_req, rd_data, irq, m_rd, m_irq);
         end
      end
   end

   task automatic cyc(bit w, bit r, logic [3:0] i, logic [7:0] d, bit t);
      wr_en = w; rd_en = r; reg_idx = i; wr_data = d; tick_en = t;
      @(negedge clk);
      wr_en = 0; rd_en = 0; tick_en = 0;
   endtask

   task automatic chk_rd(logic [3:0] i, logic [7:0] exp, string req);
      cyc(0, 1, i, 8'h00, 0);
      n_cmp++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s: idx %0d rd_data=%02h expected %02h", req, i, rd_data, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 190000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1 reset state
      cur_req = "R1";
      chk_rd(4, 8'hFF, "R1"); chk_rd(5, 8'hFF, "R1");
      chk_rd(6, 8'hFF, "R1"); chk_rd(7, 8'hFF, "R1");
      chk_rd(8, 8'hFF, "R1"); chk_rd(9, 8'hFF, "R1");
      chk_rd(13, 8'h00, "R1"); chk_rd(14, 8'h00, "R1"); chk_rd(11, 8'h00, "R1");
      // R2 decrement and hold
      cur_req = "R2";
      repeat (5) cyc(0, 0, 0, 0, 1);
      repeat (3) cyc(0, 0, 0, 0, 0);
      chk_rd(4, 8'hFA, "R2"); chk_rd(8, 8'hFA, "R2");
      // R3 merge writes, write beats tick
      cur_req = "R3";
      cyc(1, 0, 4, 8'h03, 1);
      chk_rd(5, 8'hFF, "R3");
      cyc(1, 0, 5, 8'h00, 1);
      chk_rd(4, 8'h03, "R3"); chk_rd(5, 8'h00, "R3");
      // R5 one-shot: flag once, then a full lap without a flag
      cur_req = "R5";
      cyc(1, 0, 14, 8'hC0, 0);
      repeat (6) cyc(0, 0, 0, 0, 1);
      chk_rd(13, 8'h40, "R5"); chk_rd(5, 8'hFF, "R5");
      cyc(1, 0, 13, 8'h40, 0);
      repeat (65540) cyc(0, 0, 0, 0, 1);
      chk_rd(13, 8'h00, "R5");
      // R4 continuous mode with short period, irregular ticks
      cur_req = "R4";
      cyc(1, 0, 6, 8'h03, 0); cyc(1, 0, 7, 8'h00, 0);
      chk_rd(6, 8'h03, "R4");
      cyc(1, 0, 11, 8'h40, 0);
      cyc(1, 0, 4, 8'h02, 0); cyc(1, 0, 5, 8'h00, 0);
      for (int k = 0; k < 40; k++) cyc(0, 0, 0, 0, (k % 3) != 1);
      chk_rd(13, 8'h40, "R4");
      // R6 read clears, including coincidence with expiry
      cur_req = "R6";
      for (int k = 0; k < 30; k++) cyc(0, 1, (k % 2) ? 4'd5 : 4'd4, 0, 1);
      // R7 flag write clears only bits written as 1
      cur_req = "R7";
      cyc(1, 0, 11, 8'h00, 0);
      cyc(1, 0, 4, 8'h01, 0); cyc(1, 0, 5, 8'h00, 0);
      repeat (3) cyc(0, 0, 0, 0, 1);
      cyc(1, 0, 13, 8'h3F, 0);
      chk_rd(13, 8'h40, "R7");
      cyc(1, 0, 13, 8'h40, 0);
      chk_rd(13, 8'h00, "R7");
      // R8 enable set/clear
      cur_req = "R8";
      cyc(1, 0, 14, 8'hFF, 0); chk_rd(14, 8'h7F, "R8");
      cyc(1, 0, 14, 8'h05, 0); chk_rd(14, 8'h7A, "R8");
      cyc(1, 0, 14, 8'h7F, 0); chk_rd(14, 8'h00, "R8");
      // R9 irq gating by enable
      cur_req = "R9";
      cyc(1, 0, 4, 8'h00, 0); cyc(1, 0, 5, 8'h00, 0);
      repeat (3) cyc(0, 0, 0, 0, 1);
      cyc(1, 0, 14, 8'hC0, 0);
      repeat (3) cyc(0, 0, 0, 0, 0);
      cyc(1, 0, 14, 8'h40, 0);
      repeat (3) cyc(0, 0, 0, 0, 0);
      // R10 unmapped indices and held read data
      cur_req = "R10";
      cyc(1, 0, 0, 8'h55, 0); cyc(1, 0, 15, 8'hAA, 0);
      chk_rd(0, 8'h00, "R10"); chk_rd(15, 8'h00, "R10");
      chk_rd(10, 8'h00, "R10"); chk_rd(12, 8'h00, "R10");
      repeat (4) cyc(0, 0, 0, 0, 1);
      // R2 timer 2 wrap and continuous-mode exit
      cur_req = "R2";
      cyc(1, 0, 8, 8'h01, 0); cyc(1, 0, 9, 8'h00, 0);
      repeat (3) cyc(0, 0, 0, 0, 1);
      chk_rd(8, 8'hFE, "R2"); chk_rd(9, 8'hFF, "R2");
      cyc(1, 0, 11, 8'h40, 0);
      cyc(1, 0, 11, 8'h00, 0);
      repeat (20) cyc(0, 0, 0, 0, 1);
      repeat (2) cyc(0, 0, 0, 0, 0);
      finish_run();
   end
endmodule